// File: doc/BRIEF.md
# Dual Image Checksum Verifier with Backup Selection

This block checks two stored images at start-up: a boot image and a configuration image for a programmable logic device. After a start pulse it reads each image one 32-bit word per clock through a simple memory read port. It folds every word into a CRC32 and compares the finished checksum with a reference value. The base address, word count and reference checksum of each image arrive as input registers, so the memory contents and the directory parsing stay outside the block.

The boot image is read first and the configuration image second. A failed boot image sets a select output that steers the boot loader to the backup boot copy. A failed configuration image raises a level request to reprogram the device from its backup copy. That request stays high until the consumer acknowledges it. A one-cycle done pulse marks the end of a run. Per-image pass flags are valid from the done cycle onward.

Top module: `img_crc_guard`

## Requirements
- R1: After reset, memRdEn, busy, done, bootPass, cfgPass, bootSelBackup and reprogReq are all 0.
- R2: The checksum is a CRC32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. Each word is consumed in one step, least significant bit first, which is equivalent to the bytes in order [7:0], [15:8], [23:16], [31:24]. An image passes only when the result equals its reference checksum.
- R3: A run issues exactly one read per word, at most one per clock. It reads the boot image first, at addresses base to base+len-1 in increasing order, and then the configuration image in the same way. memRdData must return the addressed word on the clock after memRdEn.
- R4: When done pulses, bootPass is 1 if the boot image passed and 0 otherwise. bootSelBackup is the inverse of bootPass, so 1 selects the backup boot copy. It holds until the next boot check.
- R5: A failed configuration check sets reprogReq, and reprogReq stays 1 until reprogAck is sampled high. A set in the same clock as an acknowledge wins over the acknowledge. A passing configuration check does not clear a pending request.
- R6: An image of length 0 is reported as failed, and no reads are issued for it.
- R7: done is a single-cycle pulse that occurs once per run after both images are checked, with busy already low. busy is high from the clock after start until the run ends.
- R8: A start pulse while busy is high is ignored: no second run, no extra reads, no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| bootBase | input | ADDR_W | First word address of the boot image |
| bootLen | input | LEN_W | Boot image length in words |
| bootRefCrc | input | 32 | Reference checksum for the boot image |
| cfgBase | input | ADDR_W | First word address of the configuration image |
| cfgLen | input | LEN_W | Configuration image length in words |
| cfgRefCrc | input | 32 | Reference checksum for the configuration image |
| memRdEn | output | 1 | Read strobe to image memory |
| memAddr | output | ADDR_W | Word address of the read |
| memRdData | input | 32 | Read data, valid one clock after memRdEn |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at end of run |
| bootPass | output | 1 | Boot image checksum matched |
| cfgPass | output | 1 | Configuration image checksum matched |
| bootSelBackup | output | 1 | 1 selects the backup boot copy |
| reprogReq | output | 1 | Request to reprogram the device from the backup configuration |
| reprogAck | input | 1 | Clears reprogReq |

## Verification
The assertions rely on three conditions:
- the memory answers every read on the very next clock;
- base plus length never wraps the address space, so consecutive reads step by exactly one;
- reprogAck is a well-formed acknowledge whose only effect is to drop the request.

The bench keeps to these conditions. It uses a synchronous memory model with a fixed one-clock latency and places both images well inside a 256-word region. It raises acknowledges only when it means to clear the request, and it drives every input on the falling edge.

// File: rtl/img_crc_pkg.sv
package img_crc_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_XOROUT = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOOT_RD,
    ST_BOOT_CHK,
    ST_CFG_RD,
    ST_CFG_CHK
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBoot;
    logic loadCfg;
    logic issueRd;
    logic latchBoot;
    logic latchCfg;
  } ctrlStrobe_t;

  // one full 32-bit word folded into the running reflected CRC, LSB first
  function automatic logic [31:0] crc32Word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/img_crc_datapath.sv
module img_crc_datapath
  import img_crc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] bootBase,
  input  logic [LEN_W-1:0]  bootLen,
  input  logic [31:0]       bootRefCrc,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [31:0]       cfgRefCrc,
  input  logic [31:0]       memRdData,
  input  logic              reprogAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic              remainZero,
  output logic              rdPend,
  output logic              bootPass,
  output logic              cfgPass,
  output logic              bootSelBackup,
  output logic              reprogReq
);

  logic [ADDR_W-1:0] addrCnt;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       crcAcc;
  logic [31:0]       curRef;
  logic              curEmpty;
  logic              imgMatch;

  assign memAddr    = addrCnt;
  assign remainZero = (remain == '0);
  assign imgMatch   = !curEmpty && ((crcAcc ^ CRC_XOROUT) == curRef);

  // address walk, word countdown and reference capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrCnt  <= '0;
      remain   <= '0;
      curRef   <= '0;
      curEmpty <= 1'b1;
      rdPend   <= 1'b0;
    end else begin
      rdPend <= strb.issueRd;
      if (strb.loadBoot) begin
        addrCnt  <= bootBase;
        remain   <= bootLen;
        curRef   <= bootRefCrc;
        curEmpty <= (bootLen == '0);
      end else if (strb.loadCfg) begin
        addrCnt  <= cfgBase;
        remain   <= cfgLen;
        curRef   <= cfgRefCrc;
        curEmpty <= (cfgLen == '0);
      end else if (strb.issueRd) begin
        addrCnt <= addrCnt + 1'b1;
        remain  <= remain - 1'b1;
      end
    end
  end

  // checksum accumulator: data arrives one clock after the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcAcc <= CRC_SEED;
    end else if (strb.loadBoot || strb.loadCfg) begin
      crcAcc <= CRC_SEED;
    end else if (rdPend) begin
      crcAcc <= crc32Word(crcAcc, memRdData);
    end
  end

  // verdicts and recovery actions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bootPass      <= 1'b0;
      cfgPass       <= 1'b0;
      bootSelBackup <= 1'b0;
      reprogReq     <= 1'b0;
    end else begin
      if (strb.loadBoot) begin
        bootPass <= 1'b0;
        cfgPass  <= 1'b0;
      end
      if (strb.latchBoot) begin
        bootPass      <= imgMatch;
        bootSelBackup <= !imgMatch;
      end
      if (strb.latchCfg) cfgPass <= imgMatch;
      if (strb.latchCfg && !imgMatch) reprogReq <= 1'b1;
      else if (reprogAck) reprogReq <= 1'b0;
    end
  end

endmodule

// File: rtl/img_crc_ctrl.sv
module img_crc_ctrl
  import img_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        remainZero,
  input  logic        rdPend,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);

  ctrlState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadBoot = 1'b1;
          stateNxt      = ST_BOOT_RD;
        end
      end
      ST_BOOT_RD: begin
        strb.issueRd = !remainZero;
        if (remainZero && !rdPend) stateNxt = ST_BOOT_CHK;
      end
      ST_BOOT_CHK: begin
        strb.latchBoot = 1'b1;
        strb.loadCfg   = 1'b1;
        stateNxt       = ST_CFG_RD;
      end
      ST_CFG_RD: begin
        strb.issueRd = !remainZero;
        if (remainZero && !rdPend) stateNxt = ST_CFG_CHK;
      end
      ST_CFG_CHK: begin
        strb.latchCfg = 1'b1;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_CFG_CHK);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/img_crc_guard.sv
module img_crc_guard
  import img_crc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] bootBase,
  input  logic [LEN_W-1:0]  bootLen,
  input  logic [31:0]       bootRefCrc,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [31:0]       cfgRefCrc,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              busy,
  output logic              done,
  output logic              bootPass,
  output logic              cfgPass,
  output logic              bootSelBackup,
  output logic              reprogReq,
  input  logic              reprogAck
);

  ctrlStrobe_t strb;
  logic        remainZero;
  logic        rdPend;

  img_crc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .remainZero(remainZero),
    .rdPend    (rdPend),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  img_crc_datapath #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .bootBase     (bootBase),
    .bootLen      (bootLen),
    .bootRefCrc   (bootRefCrc),
    .cfgBase      (cfgBase),
    .cfgLen       (cfgLen),
    .cfgRefCrc    (cfgRefCrc),
    .memRdData    (memRdData),
    .reprogAck    (reprogAck),
    .memAddr      (memAddr),
    .remainZero   (remainZero),
    .rdPend       (rdPend),
    .bootPass     (bootPass),
    .cfgPass      (cfgPass),
    .bootSelBackup(bootSelBackup),
    .reprogReq    (reprogReq)
  );

  assign memRdEn = strb.issueRd;

endmodule

// File: rtl/img_crc_guard_chk.sv
module img_crc_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              done,
  input logic              bootPass,
  input logic              cfgPass,
  input logic              bootSelBackup,
  input logic              reprogReq,
  input logic              reprogAck
);

  // R3: back-to-back reads walk upward by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn && $past(memRdEn) |-> memAddr == $past(memAddr) + 1'b1);

  // R3: reads only happen inside a run
  a_r3_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> busy);

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done only once the run has ended
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: the boot select follows the boot verdict
  a_r4_sel_tracks_pass: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bootSelBackup == !bootPass);

  // R5: a failed configuration image leaves a request pending
  a_r5_req_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfgPass |-> reprogReq);

  // R5: the request holds until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reprogReq && !reprogAck |=> reprogReq);

endmodule

bind img_crc_guard img_crc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .memRdEn      (memRdEn),
  .memAddr      (memAddr),
  .busy         (busy),
  .done         (done),
  .bootPass     (bootPass),
  .cfgPass      (cfgPass),
  .bootSelBackup(bootSelBackup),
  .reprogReq    (reprogReq),
  .reprogAck    (reprogAck)
);

// File: tb/img_crc_guard_test.sv
`timescale 1ns/1ps
module img_crc_guard_test;

  localparam int ADDR_W = 16;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] bootBase = '0, cfgBase = '0;
  logic [LEN_W-1:0]  bootLen = '0, cfgLen = '0;
  logic [31:0] bootRefCrc = '0, cfgRefCrc = '0;
  logic memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memRdData = '0;
  logic busy, done, bootPass, cfgPass, bootSelBackup, reprogReq;
  logic reprogAck = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int doneCount = 0;
  logic reqModel = 1'b0;
  logic [31:0] mem [256];
  logic [ADDR_W-1:0] expAddr[$];

  always #5 clk = ~clk;

  img_crc_guard #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (.*);

  // synchronous memory, one clock of latency
  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[7:0]];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // per-clock comparison of the read stream against the expected queue
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (memRdEn) begin
        if (expAddr.size() == 0) check("R3", "unexpected read", 32'(memAddr), 32'hFFFF_FFFF);
        else check("R3", "read address", 32'(memAddr), 32'(expAddr.pop_front()));
      end
      if (done) doneCount++;
    end
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  // behavioural CRC32, processed one byte at a time
  function automatic logic [31:0] modelCrc(input int base, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = 0; w < len; w++) begin
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, mem[(base + w) % 256][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic runImages(input int bB, input int bL, input logic [31:0] bR,
                           input int cB, input int cL, input logic [31:0] cR,
                           input bit restart);
    logic expBoot, expCfg;
    int waitCnt;
    expBoot = (bL != 0) && (modelCrc(bB, bL) == bR);
    expCfg  = (cL != 0) && (modelCrc(cB, cL) == cR);
    for (int i = 0; i < bL; i++) expAddr.push_back(ADDR_W'(bB + i));
    for (int i = 0; i < cL; i++) expAddr.push_back(ADDR_W'(cB + i));
    if (!expCfg) reqModel = 1'b1;
    doneCount = 0;
    @(negedge clk);
    bootBase = ADDR_W'(bB); bootLen = LEN_W'(bL); bootRefCrc = bR;
    cfgBase = ADDR_W'(cB); cfgLen = LEN_W'(cL); cfgRefCrc = cR;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "busy after start", 32'(busy), 32'd1);
    if (restart) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    check("R7", "done seen", 32'(done), 32'd1);
    check("R7", "busy at done", 32'(busy), 32'd0);
    check("R4", "bootPass", 32'(bootPass), 32'(expBoot));
    check("R4", "bootSelBackup", 32'(bootSelBackup), 32'(!expBoot));
    check("R2", "cfgPass", 32'(cfgPass), 32'(expCfg));
    check("R5", "reprogReq", 32'(reprogReq), 32'(reqModel));
    repeat (6) @(negedge clk);
    check("R8", "single done per run", 32'(doneCount), 32'd1);
    check("R3", "all reads issued", 32'(expAddr.size()), 32'd0);
    check("R8", "idle after run", 32'(busy), 32'd0);
    expAddr.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E3779B1) ^ (i << 7);
    mem[8'h40] = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "memRdEn", 32'(memRdEn), 32'd0);
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "done", 32'(done), 32'd0);
    check("R1", "flags", {28'd0, bootPass, cfgPass, bootSelBackup, reprogReq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: known value, CRC32 of four zero bytes
    check("R2", "model zero word", modelCrc(32'h40, 1), 32'h2144DF1C);
    runImages(32'h40, 1, 32'h2144DF1C, 32'h10, 3, modelCrc(32'h10, 3), 1'b0);

    // R2 R3: both images good
    runImages(32'h20, 5, modelCrc(32'h20, 5), 32'h80, 7, modelCrc(32'h80, 7), 1'b0);

    // R4: boot image corrupt
    runImages(32'h20, 5, modelCrc(32'h20, 5) ^ 32'h1, 32'h80, 7, modelCrc(32'h80, 7), 1'b0);

    // R4: boot image good again, select returns to primary
    runImages(32'h30, 2, modelCrc(32'h30, 2), 32'h90, 4, modelCrc(32'h90, 4), 1'b0);

    // R5: configuration image corrupt, request held
    runImages(32'h30, 2, modelCrc(32'h30, 2), 32'h90, 4, ~modelCrc(32'h90, 4), 1'b0);
    repeat (5) @(negedge clk);
    check("R5", "request held without ack", 32'(reprogReq), 32'd1);

    // R5: a passing run does not clear a pending request
    runImages(32'h30, 2, modelCrc(32'h30, 2), 32'h90, 4, modelCrc(32'h90, 4), 1'b0);

    // R5: acknowledge clears it
    reprogAck = 1'b1;
    @(negedge clk);
    reprogAck = 1'b0;
    reqModel = 1'b0;
    check("R5", "request cleared by ack", 32'(reprogReq), 32'd0);

    // R6: zero-length boot image, zero-length configuration image
    runImages(32'h50, 0, modelCrc(32'h50, 0), 32'hA0, 3, modelCrc(32'hA0, 3), 1'b0);
    runImages(32'h50, 4, modelCrc(32'h50, 4), 32'hA0, 0, modelCrc(32'hA0, 0), 1'b0);
    reprogAck = 1'b1;
    @(negedge clk);
    reprogAck = 1'b0;
    reqModel = 1'b0;

    // R8: a start pulse during a run is ignored
    runImages(32'h60, 9, modelCrc(32'h60, 9), 32'hC0, 6, modelCrc(32'hC0, 6), 1'b1);

    finishRun();
  end

endmodule